// File: doc/BRIEF.md
# Temperature-Compensated Wiper Update Controller

This block owns the 7-bit tap setting of a 128-position digital potentiometer. It has three modes, chosen by two configuration bits. In host-direct mode the register interface writes the wiper. In table mode the wiper follows a per-temperature table entry. In offset mode a signed table entry is added to a stored initial value. An internal frame timer stands in for the periodic temperature conversion. At the end of each frame the block reads one table entry and, unless something gates it, loads the wiper.

Reset loads the wiper from the initial-value register. In the table modes the wiper keeps that value until the first conversion finishes. A manual-override bit stops automatic loads in the table modes and lets the host write the wiper. A standby bit freezes the wiper and restarts the frame timer, so automatic updates come back only after one whole frame. The table port is external. Its read latency is a parameter (0 for a combinational table, 1 for a registered one).

Top module: `wiper_comp_ctrl`

## Requirements
- R1: After reset the wiper and the initial value both equal IVR_INIT (default 40h), and the wiper MSB is 0.
- R2: mode_o is 0 (host-direct) whenever cfg_update_mode is 0, whatever cfg_adder_mode is. With cfg_update_mode 1, mode_o is 1 (table) for cfg_adder_mode 0 and 2 (offset) for cfg_adder_mode 1.
- R3: In host-direct mode a host_wr_we pulse sets wiper[6:0] to host_wr_data on the next clock edge. The same write also copies the value into the initial value when cfg_shadow_only is 0, and leaves the initial value unchanged when it is 1.
- R4: While cfg_standby is 0, conv_evt pulses for one cycle every FRAME_TICKS cycles. The first pulse comes FRAME_TICKS-1 edges after reset release or after standby clears.
- R5: In table mode, TBL_LAT+1 edges after conv_evt, the wiper takes tbl_data[6:0]. Until the first conversion after reset, it keeps the reset value.
- R6: In offset mode the wiper takes initial value + tbl_data, where tbl_data is read as signed 8-bit two's complement. The result saturates to 0..127.
- R7: In the table modes, cfg_manual=1 blocks every automatic load and lets host_wr_we write the wiper. With cfg_manual=0, host_wr_we has no effect on the wiper in those modes.
- R8: cfg_standby=1 blocks automatic loads and holds the frame timer at its start. After standby clears, the next automatic load arrives only after a full frame (FRAME_TICKS+1 edges with TBL_LAT=1).
- R9: wiper[7] is always 0.
- R10: A host_ivr_we pulse sets the initial value to host_ivr_data on the next edge in any mode, and does not change the wiper.
- R11: In host-direct mode, conversions never change the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_update_mode | input | 1 | 1 selects a table-driven mode |
| cfg_adder_mode | input | 1 | In table-driven modes, 1 selects offset mode |
| cfg_shadow_only | input | 1 | 1 keeps host-direct writes out of the initial value |
| cfg_manual | input | 1 | Manual override in table modes |
| cfg_standby | input | 1 | Freeze updates and restart the frame |
| host_wr_we | input | 1 | Host wiper write strobe |
| host_wr_data | input | 7 | Host wiper value |
| host_ivr_we | input | 1 | Host initial-value write strobe |
| host_ivr_data | input | 7 | Host initial value |
| tbl_data | input | 8 | Table entry at the current temperature index |
| conv_evt | output | 1 | Conversion-complete pulse (table read strobe) |
| wiper | output | 8 | Wiper setting, MSB held 0 |
| ivr_o | output | 7 | Current initial value |
| mode_o | output | 2 | Decoded mode: 0 host, 1 table, 2 offset |

## Verification
The offset arithmetic is tried with positive, negative, zero and extreme entries. This separates sign handling, exact limits (sums landing on 0 and 127) and saturation above 127 and below 0 from a wrapping adder. Table-mode entries with bit 7 set show that the MSB is masked and not passed through. Frame timing is measured at reset release and at standby release, which separates "resume after a full frame" from "resume at once". Host writes are applied in each mode with and without override, and with shadow on and off, to show which register each write touches.

// File: rtl/wcc_pkg.sv
`timescale 1ns/1ps
package wcc_pkg;
  localparam int unsigned TAP_BITS   = 7;
  localparam int unsigned ENTRY_BITS = 8;
  localparam int unsigned SUM_BITS   = ENTRY_BITS + 1;

  typedef enum logic [1:0] {
    MODE_HOST   = 2'd0,
    MODE_TABLE  = 2'd1,
    MODE_OFFSET = 2'd2
  } wcc_mode_e;

  function automatic wcc_mode_e decode_mode(input logic upd, input logic add);
    if (!upd)     return MODE_HOST;
    else if (add) return MODE_OFFSET;
    else          return MODE_TABLE;
  endfunction

  // signed entry added to the unsigned base, clamped into the tap range
  function automatic logic [TAP_BITS-1:0] sat_offset(
    input logic [TAP_BITS-1:0]   base,
    input logic [ENTRY_BITS-1:0] delta
  );
    logic signed [SUM_BITS-1:0] sum;
    sum = $signed({{(SUM_BITS-TAP_BITS){1'b0}}, base}) +
          $signed({delta[ENTRY_BITS-1], delta});
    if (sum[SUM_BITS-1])
      return '0;
    else if (|sum[SUM_BITS-2:TAP_BITS])
      return {TAP_BITS{1'b1}};
    else
      return sum[TAP_BITS-1:0];
  endfunction

  function automatic logic [TAP_BITS-1:0] table_value(
    input wcc_mode_e             mode,
    input logic [TAP_BITS-1:0]   base,
    input logic [ENTRY_BITS-1:0] entry
  );
    if (mode == MODE_OFFSET) return sat_offset(base, entry);
    else                     return entry[TAP_BITS-1:0];
  endfunction
endpackage

// File: rtl/wcc_frame_timer.sv
`timescale 1ns/1ps
module wcc_frame_timer #(
  parameter int unsigned FRAME_TICKS = 1_600_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic evt
);
  localparam int unsigned CNT_W = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign evt = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (evt)    cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wcc_fetch.sv
`timescale 1ns/1ps
module wcc_fetch #(
  parameter int unsigned TBL_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_evt,
  output logic data_ready
);
  generate
    if (TBL_LAT == 0) begin : g_comb
      assign data_ready = rd_evt;
    end else if (TBL_LAT == 1) begin : g_one
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= rd_evt;
      end
      assign data_ready = stage_q;
    end else begin : g_multi
      logic [TBL_LAT-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[TBL_LAT-2:0], rd_evt};
      end
      assign data_ready = pipe_q[TBL_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/wcc_wiper_reg.sv
`timescale 1ns/1ps
module wcc_wiper_reg
  import wcc_pkg::*;
#(
  parameter logic [TAP_BITS-1:0] IVR_INIT = 7'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  wcc_mode_e             mode,
  input  logic                  shadow_only,
  input  logic                  manual,
  input  logic                  standby,
  input  logic                  host_wr_we,
  input  logic [TAP_BITS-1:0]   host_wr_data,
  input  logic                  host_ivr_we,
  input  logic [TAP_BITS-1:0]   host_ivr_data,
  input  logic                  data_ready,
  input  logic [ENTRY_BITS-1:0] tbl_data,
  output logic [TAP_BITS-1:0]   wiper_q,
  output logic [TAP_BITS-1:0]   ivr_q,
  output logic                  tbl_load,
  output logic                  host_wiper_ok
);
  logic table_mode;
  logic ivr_shadow_we;
  logic [TAP_BITS-1:0] loaded_val;

  assign table_mode    = (mode != MODE_HOST);
  assign tbl_load      = data_ready && table_mode && !manual && !standby;
  assign host_wiper_ok = host_wr_we && (!table_mode || manual);
  assign ivr_shadow_we = host_wr_we && !table_mode && !shadow_only;
  assign loaded_val    = table_value(mode, ivr_q, tbl_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wiper_q <= IVR_INIT;
    else if (host_wiper_ok) wiper_q <= host_wr_data;
    else if (tbl_load)      wiper_q <= loaded_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ivr_q <= IVR_INIT;
    else if (host_ivr_we)   ivr_q <= host_ivr_data;
    else if (ivr_shadow_we) ivr_q <= host_wr_data;
  end
endmodule

// File: rtl/wiper_comp_ctrl.sv
`timescale 1ns/1ps
module wiper_comp_ctrl
  import wcc_pkg::*;
#(
  parameter int unsigned         FRAME_TICKS = 1_600_000,
  parameter int unsigned         TBL_LAT     = 1,
  parameter logic [TAP_BITS-1:0] IVR_INIT    = 7'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_update_mode,
  input  logic                  cfg_adder_mode,
  input  logic                  cfg_shadow_only,
  input  logic                  cfg_manual,
  input  logic                  cfg_standby,
  input  logic                  host_wr_we,
  input  logic [TAP_BITS-1:0]   host_wr_data,
  input  logic                  host_ivr_we,
  input  logic [TAP_BITS-1:0]   host_ivr_data,
  input  logic [ENTRY_BITS-1:0] tbl_data,
  output logic                  conv_evt,
  output logic [TAP_BITS:0]     wiper,
  output logic [TAP_BITS-1:0]   ivr_o,
  output logic [1:0]            mode_o
);
  wcc_mode_e           mode;
  logic                frame_evt;
  logic                data_ready;
  logic                tbl_load;
  logic                host_wiper_ok;
  logic [TAP_BITS-1:0] wiper_q;

  assign mode = decode_mode(cfg_update_mode, cfg_adder_mode);

  wcc_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) timer_i (
    .clk (clk),
    .rst_n (rst_n),
    .run (!cfg_standby),
    .evt (frame_evt)
  );

  wcc_fetch #(.TBL_LAT(TBL_LAT)) fetch_i (
    .clk (clk),
    .rst_n (rst_n),
    .rd_evt (frame_evt),
    .data_ready (data_ready)
  );

  wcc_wiper_reg #(.IVR_INIT(IVR_INIT)) wreg_i (
    .clk (clk),
    .rst_n (rst_n),
    .mode (mode),
    .shadow_only (cfg_shadow_only),
    .manual (cfg_manual),
    .standby (cfg_standby),
    .host_wr_we (host_wr_we),
    .host_wr_data (host_wr_data),
    .host_ivr_we (host_ivr_we),
    .host_ivr_data (host_ivr_data),
    .data_ready (data_ready),
    .tbl_data (tbl_data),
    .wiper_q (wiper_q),
    .ivr_q (ivr_o),
    .tbl_load (tbl_load),
    .host_wiper_ok (host_wiper_ok)
  );

  assign conv_evt = frame_evt;
  assign wiper    = {1'b0, wiper_q};
  assign mode_o   = mode;
endmodule

// File: rtl/wiper_comp_ctrl_chk.sv
`timescale 1ns/1ps
module wiper_comp_ctrl_chk #(
  parameter int unsigned FRAME_TICKS = 1_600_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_update_mode,
  input logic       cfg_manual,
  input logic       cfg_standby,
  input logic       cfg_shadow_only,
  input logic       host_wr_we,
  input logic [6:0] host_wr_data,
  input logic       host_ivr_we,
  input logic [7:0] wiper,
  input logic [6:0] ivr_o,
  input logic [1:0] mode_o,
  input logic       tbl_load,
  input logic       frame_evt
);
  int unsigned since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_q <= 0;
    else if (cfg_standby || frame_evt) since_q <= 0;
    else                            since_q <= since_q + 1;
  end

  AST_WIPER_MSB_LOW: assert property (@(posedge clk) disable iff (!rst_n) !wiper[7]); // R9
  AST_HOST_MODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_update_mode |-> mode_o == 2'd0); // R2
  AST_HOST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_update_mode && host_wr_we) |=> wiper[6:0] == $past(host_wr_data)); // R3
  AST_SHADOW_KEEPS_IVR: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_update_mode && host_wr_we && cfg_shadow_only && !host_ivr_we) |=> $stable(ivr_o)); // R3
  AST_NO_LOAD_HOST_MODE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_update_mode |-> !tbl_load); // R11
  AST_MANUAL_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (cfg_update_mode && cfg_manual) |-> !tbl_load); // R7
  AST_TABLE_IGNORES_HOST: assert property (@(posedge clk) disable iff (!rst_n) (cfg_update_mode && !cfg_manual && !tbl_load) |=> $stable(wiper)); // R7
  AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_standby && !host_wr_we) |=> $stable(wiper)); // R8
  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) frame_evt |-> since_q == FRAME_TICKS - 1); // R4
endmodule

bind wiper_comp_ctrl wiper_comp_ctrl_chk #(.FRAME_TICKS(FRAME_TICKS)) chk_i (
  .clk (clk),
  .rst_n (rst_n),
  .cfg_update_mode (cfg_update_mode),
  .cfg_manual (cfg_manual),
  .cfg_standby (cfg_standby),
  .cfg_shadow_only (cfg_shadow_only),
  .host_wr_we (host_wr_we),
  .host_wr_data (host_wr_data),
  .host_ivr_we (host_ivr_we),
  .wiper (wiper),
  .ivr_o (ivr_o),
  .mode_o (mode_o),
  .tbl_load (tbl_load),
  .frame_evt (frame_evt)
);

// File: tb/wiper_comp_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_comp_ctrl_tb_top;
  localparam int unsigned F = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_update_mode = 0, cfg_adder_mode = 0, cfg_shadow_only = 0;
  logic cfg_manual = 0, cfg_standby = 0;
  logic host_wr_we = 0, host_ivr_we = 0;
  logic [6:0] host_wr_data = '0, host_ivr_data = '0;
  logic [7:0] tbl_data = '0;
  logic conv_evt;
  logic [7:0] wiper;
  logic [6:0] ivr_o;
  logic [1:0] mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wiper_comp_ctrl #(.FRAME_TICKS(F), .TBL_LAT(1), .IVR_INIT(7'h40)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_update_mode(cfg_update_mode), .cfg_adder_mode(cfg_adder_mode),
    .cfg_shadow_only(cfg_shadow_only), .cfg_manual(cfg_manual),
    .cfg_standby(cfg_standby),
    .host_wr_we(host_wr_we), .host_wr_data(host_wr_data),
    .host_ivr_we(host_ivr_we), .host_ivr_data(host_ivr_data),
    .tbl_data(tbl_data), .conv_evt(conv_evt),
    .wiper(wiper), .ivr_o(ivr_o), .mode_o(mode_o)
  );

  // {adder, ivr, entry, expected wiper}
  localparam logic [31:0] VEC [12] = '{
    {8'h00, 8'h40, 8'h25, 8'h25},
    {8'h00, 8'h40, 8'h7F, 8'h7F},
    {8'h00, 8'h40, 8'h00, 8'h00},
    {8'h00, 8'h40, 8'h85, 8'h05},
    {8'h01, 8'h40, 8'h10, 8'h50},
    {8'h01, 8'h40, 8'hF0, 8'h30},
    {8'h01, 8'h7F, 8'h01, 8'h7F},
    {8'h01, 8'h05, 8'hF0, 8'h00},
    {8'h01, 8'h60, 8'h7F, 8'h7F},
    {8'h01, 8'h00, 8'h80, 8'h00},
    {8'h01, 8'h3C, 8'hC4, 8'h00},
    {8'h01, 8'h70, 8'h0F, 8'h7F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_evt(input string req);
    for (int i = 0; i < 4 * F; i++) begin
      @(negedge clk);
      if (conv_evt) return;
    end
    check(req, 8'h00, 8'h01);
  endtask

  task automatic host_write(input logic [6:0] d);
    host_wr_data = d; host_wr_we = 1'b1;
    @(negedge clk);
    host_wr_we = 1'b0;
  endtask

  task automatic ivr_write(input logic [6:0] d);
    host_ivr_data = d; host_ivr_we = 1'b1;
    @(negedge clk);
    host_ivr_we = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int gap;
    // R1 reset state
    tbl_data = 8'h11;
    @(negedge clk); do_reset();
    check("R1 wiper", wiper, 8'h40);
    check("R1 ivr", {1'b0, ivr_o}, 8'h40);

    // R2 mode decode
    cfg_update_mode = 0; cfg_adder_mode = 1; #1;
    check("R2 host ignores adder", {6'b0, mode_o}, 8'h00);
    cfg_update_mode = 1; cfg_adder_mode = 0; #1;
    check("R2 table", {6'b0, mode_o}, 8'h01);
    cfg_adder_mode = 1; #1;
    check("R2 offset", {6'b0, mode_o}, 8'h02);

    // R3 / R9 / R11 host-direct mode
    cfg_update_mode = 0; cfg_adder_mode = 1; cfg_shadow_only = 0;
    @(negedge clk);
    host_write(7'h15);
    check("R3 wiper write", wiper, 8'h15);
    check("R3 ivr shadowed", {1'b0, ivr_o}, 8'h15);
    check("R9 msb low", {7'b0, wiper[7]}, 8'h00);
    cfg_shadow_only = 1;
    host_write(7'h22);
    check("R3 wiper write volatile", wiper, 8'h22);
    check("R3 ivr kept", {1'b0, ivr_o}, 8'h15);
    tick(3 * F);
    check("R11 no load in host mode", wiper, 8'h22);
    cfg_shadow_only = 0;

    // R4 frame period
    wait_evt("R4 first evt");
    gap = 0;
    do begin @(negedge clk); gap++; end while (!conv_evt && gap < 4 * F);
    check("R4 period", 8'(gap), 8'(F));

    // R5 / R6 vector walk
    foreach (VEC[k]) begin
      cfg_update_mode = 1;
      cfg_adder_mode  = VEC[k][24];
      ivr_write(VEC[k][22:16]);
      tbl_data = VEC[k][15:8];
      wait_evt("R5 evt");
      tick(2);
      check(VEC[k][24] ? "R6 offset" : "R5 table", wiper, VEC[k][7:0]);
    end

    // R5 hold reset value until first conversion
    cfg_update_mode = 1; cfg_adder_mode = 0; tbl_data = 8'h33;
    do_reset();
    tick(F - 1);
    check("R5 hold initial", wiper, 8'h40);
    tick(3);
    check("R5 first load", wiper, 8'h33);

    // R7 manual override
    host_write(7'h10);
    check("R7 host ignored", wiper, 8'h33);
    cfg_manual = 1; tbl_data = 8'h50;
    host_write(7'h0A);
    check("R7 manual write", wiper, 8'h0A);
    tick(3 * F);
    check("R7 no auto load", wiper, 8'h0A);
    check("R7 ivr untouched", {1'b0, ivr_o}, 8'h40);

    // R10 initial-value port
    ivr_write(7'h12);
    check("R10 ivr written", {1'b0, ivr_o}, 8'h12);
    check("R10 wiper kept", wiper, 8'h0A);
    cfg_manual = 0;

    // R8 standby
    tbl_data = 8'h20;
    wait_evt("R8 evt"); tick(2);
    check("R8 pre-standby load", wiper, 8'h20);
    cfg_standby = 1; tbl_data = 8'h60;
    tick(3 * F);
    check("R8 frozen", wiper, 8'h20);
    check("R8 no evt", {7'b0, conv_evt}, 8'h00);
    cfg_standby = 0;
    tick(F);
    check("R8 not before full frame", wiper, 8'h20);
    tick(2);
    check("R8 resumed", wiper, 8'h60);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule